// File: doc/BRIEF.md
# Page-Size and Bypass Prediction Front-End

This block stands in front of a translation table held in main memory. Each incoming virtual address first looks up a one-bit page-size guess: small (4 KB) or huge (1 GB). The guess chooses which of two separate memory regions to use. It also chooses which page-number bits form the set index. Together these give the physical address of the 64-byte entry set. One cycle later, that set address indexes a second one-bit table. This second guess decides whether the set read goes through the L2/LLC caches or goes straight to memory.

Both tables learn from feedback. The page walker reports the true page size for an address. The cache path reports whether a probe of a set address hit or missed. A lookup that misses at the guessed size is never retried at the other size. The block turns it into a page-walk request, and that walk later corrects the size table.

Top module: `pred_front`

## Requirements
- R1: After reset, every bit of both tables is 0 (small page, no bypass), and `out_valid` and `walk_req` are low.
- R2: The size guess is bit `va[29:21]` of the size table. 0 means small and 1 means huge. It is reported on `out_huge`.
- R3: For a small guess, `out_set_addr = small_base + va[23:12]*64`. For a huge guess, `out_set_addr = huge_base + va[41:30]*64`.
- R4: The route guess is bit `out_set_addr[14:6]` of the bypass table. 1 means straight to memory and 0 means through the caches. It is reported on `out_bypass`.
- R5: A request presented at clock edge k appears on the outputs after edge k+1. One request is accepted every cycle, and `out_valid` is high only for accepted requests.
- R6: A walker update writes `walk_upd_huge` into size-table entry `walk_upd_va[29:21]`.
- R7: A probe update writes into bypass entry `probe_upd_addr[14:6]`. It writes 0 when `probe_upd_hit` is 1 (hit in L2 or LLC) and 1 when `probe_upd_hit` is 0 (missed both).
- R8: If an update and a read reach the same entry in the same cycle, the read uses the value from before the update.
- R9: A reported lookup miss raises `walk_req` for one cycle on the next edge, carrying the miss address on `walk_va`. It produces no new set address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 48 | Virtual address of the request |
| small_base | input | 40 | Base of the small-page table region |
| huge_base | input | 40 | Base of the huge-page table region |
| out_valid | output | 1 | Prediction result valid |
| out_set_addr | output | 40 | Physical address of the entry set |
| out_huge | output | 1 | Predicted page size (1 = huge) |
| out_bypass | output | 1 | Predicted route (1 = skip caches) |
| walk_upd_valid | input | 1 | Walker size feedback strobe |
| walk_upd_va | input | 48 | Virtual address the walk resolved |
| walk_upd_huge | input | 1 | True page size from the walk |
| probe_upd_valid | input | 1 | Cache probe feedback strobe |
| probe_upd_addr | input | 40 | Set address that was probed |
| probe_upd_hit | input | 1 | Probe hit in L2 or LLC |
| miss_valid | input | 1 | Lookup at the guessed size missed |
| miss_va | input | 48 | Address of the missed lookup |
| walk_req | output | 1 | Page walk request |
| walk_va | output | 48 | Address for the page walk |

## Verification
The hardest case to reach is a table update that collides with a read of the same entry. For the bypass table, the probe feedback must land exactly one cycle after the request, because the set address that indexes the table only exists in the second stage. The bench drives the request on one falling edge and the matching probe update on the next. It expects the old route bit, then repeats the request to see the new bit. Full sweeps over all 512 entries of each table are made with the tables cleared, with a walker-trained pattern, and with a probe-trained pattern. Every expected set address is computed from the two base values.

// File: rtl/pred_front.sv
module pred_front #(
  parameter int VA_W     = 48,
  parameter int PA_W     = 40,
  parameter int IDX_W    = 9,
  parameter int SET_W    = 12,
  parameter int SZ_LSB   = 21,
  parameter int BY_LSB   = 6,
  parameter int SMALL_SH = 12,
  parameter int HUGE_SH  = 30,
  parameter int LINE_SH  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  input  logic [PA_W-1:0] small_base,
  input  logic [PA_W-1:0] huge_base,
  output logic            out_valid,
  output logic [PA_W-1:0] out_set_addr,
  output logic            out_huge,
  output logic            out_bypass,
  input  logic            walk_upd_valid,
  input  logic [VA_W-1:0] walk_upd_va,
  input  logic            walk_upd_huge,
  input  logic            probe_upd_valid,
  input  logic [PA_W-1:0] probe_upd_addr,
  input  logic            probe_upd_hit,
  input  logic            miss_valid,
  input  logic [VA_W-1:0] miss_va,
  output logic            walk_req,
  output logic [VA_W-1:0] walk_va
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] size_tbl;
  logic [ENTRIES-1:0] byp_tbl;

  logic            s1_valid;
  logic [PA_W-1:0] s1_addr;
  logic            s1_huge;

  wire [IDX_W-1:0] sz_idx    = req_va[SZ_LSB +: IDX_W];
  wire             pred_huge = size_tbl[sz_idx];
  wire [SET_W-1:0] set_sel   = pred_huge ? req_va[HUGE_SH +: SET_W] : req_va[SMALL_SH +: SET_W];
  wire [PA_W-1:0]  set_off   = {{(PA_W-SET_W){1'b0}}, set_sel} << LINE_SH;
  wire [PA_W-1:0]  set_addr  = (pred_huge ? huge_base : small_base) + set_off;

  wire [IDX_W-1:0] by_idx    = s1_addr[BY_LSB +: IDX_W];
  wire [IDX_W-1:0] wu_idx    = walk_upd_va[SZ_LSB +: IDX_W];
  wire [IDX_W-1:0] pu_idx    = probe_upd_addr[BY_LSB +: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_tbl <= '0;
      byp_tbl  <= '0;
    end else begin
      if (walk_upd_valid)  size_tbl[wu_idx] <= walk_upd_huge;
      if (probe_upd_valid) byp_tbl[pu_idx]  <= ~probe_upd_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid     <= 1'b0;
      s1_addr      <= '0;
      s1_huge      <= 1'b0;
      out_valid    <= 1'b0;
      out_set_addr <= '0;
      out_huge     <= 1'b0;
      out_bypass   <= 1'b0;
      walk_req     <= 1'b0;
      walk_va      <= '0;
    end else begin
      s1_valid     <= req_valid;
      s1_addr      <= set_addr;
      s1_huge      <= pred_huge;
      out_valid    <= s1_valid;
      out_set_addr <= s1_addr;
      out_huge     <= s1_huge;
      out_bypass   <= byp_tbl[by_idx];
      walk_req     <= miss_valid;
      walk_va      <= miss_va;
    end
  end
endmodule

module pred_front_chk #(
  parameter int IDX_W = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  out_valid,
  input logic                  miss_valid,
  input logic                  walk_req,
  input logic                  walk_upd_valid,
  input logic [IDX_W-1:0]      wu_idx,
  input logic                  walk_upd_huge,
  input logic                  probe_upd_valid,
  input logic [IDX_W-1:0]      pu_idx,
  input logic                  probe_upd_hit,
  input logic [(1<<IDX_W)-1:0] size_tbl,
  input logic [(1<<IDX_W)-1:0] byp_tbl
);
  // R5
  out_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid, 2));
  // R9
  walk_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> $past(miss_valid));
  // R6
  size_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_upd_valid |=> size_tbl[$past(wu_idx)] == $past(walk_upd_huge));
  // R7
  byp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_upd_valid |=> byp_tbl[$past(pu_idx)] == !$past(probe_upd_hit));
endmodule

bind pred_front pred_front_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .out_valid(out_valid),
  .miss_valid(miss_valid), .walk_req(walk_req),
  .walk_upd_valid(walk_upd_valid), .wu_idx(walk_upd_va[SZ_LSB +: IDX_W]),
  .walk_upd_huge(walk_upd_huge), .probe_upd_valid(probe_upd_valid),
  .pu_idx(probe_upd_addr[BY_LSB +: IDX_W]), .probe_upd_hit(probe_upd_hit),
  .size_tbl(size_tbl), .byp_tbl(byp_tbl)
);

// File: tb/tb_pred_front.sv
module tb_pred_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_va = '0;
  logic [39:0] small_base = 40'h10_0000_0000;
  logic [39:0] huge_base  = 40'h20_0000_0000;
  logic        out_valid, out_huge, out_bypass, walk_req;
  logic [39:0] out_set_addr;
  logic [47:0] walk_va;
  logic        walk_upd_valid = 1'b0, walk_upd_huge = 1'b0;
  logic [47:0] walk_upd_va = '0;
  logic        probe_upd_valid = 1'b0, probe_upd_hit = 1'b0;
  logic [39:0] probe_upd_addr = '0;
  logic        miss_valid = 1'b0;
  logic [47:0] miss_va = '0;

  int errors = 0, checks = 0;
  bit size_m [512];
  bit byp_m  [512];

  pred_front dut (.*);

  always #10 clk = ~clk;

  function automatic logic [39:0] exp_addr(input logic [47:0] va);
    if (size_m[va[29:21]]) return huge_base + {28'd0, va[41:30]} * 40'd64;
    return small_base + {28'd0, va[23:12]} * 40'd64;
  endfunction

  function automatic logic [47:0] mk_va(input int i);
    logic [47:0] v = '0;
    v[29:21] = i[8:0];
    v[20:12] = 9'((i * 7) & 511);
    v[41:30] = 12'((i * 13 + 5) & 4095);
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // single request, checked two edges later (R5 latency)
  task automatic one_req(input logic [47:0] va, input string tag);
    logic [39:0] ea;
    ea = exp_addr(va);
    @(negedge clk); req_valid = 1'b1; req_va = va;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R5 valid"}, 64'(out_valid), 64'd1);
    chk({tag, " R2 size"}, 64'(out_huge), 64'(size_m[va[29:21]]));
    chk({tag, " R3 addr"}, 64'(out_set_addr), 64'(ea));
    chk({tag, " R4 bypass"}, 64'(out_bypass), 64'(byp_m[ea[14:6]]));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] va;
    logic [39:0] ea;
    logic [39:0] pipe_a [16];
    bit pipe_h [16], pipe_b [16];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 walk_req", 64'(walk_req), 64'd0);

    // R1 all-zero tables seen through full sweep
    for (int i = 0; i < 512; i++) one_req(mk_va(i), "R1 sweep");

    // R6 walker training, back to back
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      walk_upd_valid = 1'b1; walk_upd_va = mk_va(i) ^ 48'h0000_0010_0000; // low bits vary
      walk_upd_huge = (i % 3 == 0);
      size_m[i] = (i % 3 == 0);
    end
    @(negedge clk); walk_upd_valid = 1'b0;
    for (int i = 0; i < 512; i++) one_req(mk_va(i), "R6 sweep");

    // R7 probe training: hit clears (even), miss sets (odd)
    for (int j = 0; j < 512; j++) begin
      @(negedge clk);
      probe_upd_valid = 1'b1; probe_upd_addr = 40'(j) << 6;
      probe_upd_hit = (j % 2 == 0);
      byp_m[j] = (j % 2 != 0);
    end
    @(negedge clk); probe_upd_valid = 1'b0;
    for (int i = 0; i < 512; i++) one_req(mk_va(i), "R7 sweep");

    // R5 back-to-back pipeline
    for (int k = 0; k < 18; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk("R5 pipe valid", 64'(out_valid), 64'd1);
        chk("R5 pipe addr", 64'(out_set_addr), 64'(pipe_a[k-2]));
        chk("R5 pipe size", 64'(out_huge), 64'(pipe_h[k-2]));
        chk("R5 pipe bypass", 64'(out_bypass), 64'(pipe_b[k-2]));
      end
      if (k < 16) begin
        va = mk_va(k * 31 + 3);
        pipe_a[k] = exp_addr(va);
        pipe_h[k] = size_m[va[29:21]];
        pipe_b[k] = byp_m[pipe_a[k][14:6]];
        req_valid = 1'b1; req_va = va;
      end else req_valid = 1'b0;
    end
    @(negedge clk);
    chk("R5 idle valid", 64'(out_valid), 64'd0);

    // R8 size collision: read sees old, then new
    va = mk_va(6);
    ea = exp_addr(va);
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    walk_upd_valid = 1'b1; walk_upd_va = va; walk_upd_huge = ~size_m[6];
    @(negedge clk); req_valid = 1'b0; walk_upd_valid = 1'b0;
    @(negedge clk);
    chk("R8 size old", 64'(out_huge), 64'(size_m[6]));
    chk("R8 addr old", 64'(out_set_addr), 64'(ea));
    size_m[6] = ~size_m[6];
    one_req(va, "R8 size new");

    // R8 bypass collision: update lands while stage 2 reads
    va = mk_va(40);
    ea = exp_addr(va);
    @(negedge clk); req_valid = 1'b1; req_va = va;
    @(negedge clk); req_valid = 1'b0;
    probe_upd_valid = 1'b1; probe_upd_addr = ea; probe_upd_hit = byp_m[ea[14:6]];
    @(negedge clk); probe_upd_valid = 1'b0;
    chk("R8 bypass old", 64'(out_bypass), 64'(byp_m[ea[14:6]]));
    byp_m[ea[14:6]] = ~byp_m[ea[14:6]];
    one_req(va, "R8 bypass new");

    // R9 miss -> walk request, no retry
    @(negedge clk); miss_valid = 1'b1; miss_va = 48'h0123_4567_89AB;
    @(negedge clk); miss_valid = 1'b0;
    chk("R9 walk_req", 64'(walk_req), 64'd1);
    chk("R9 walk_va", 64'(walk_va), 64'h0123_4567_89AB);
    chk("R9 no out", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R9 walk pulse", 64'(walk_req), 64'd0);
    chk("R9 no retry", 64'(out_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule